// File: doc/BRIEF.md
# Level-Sensitive DMA Request Acceptor

This block handles request acceptance and cycle sequencing for one DMA channel. The channel runs single-address transfers, and an active-low external request line triggers them. A write to the channel's enable control arms the block and loads a transfer count. From the next clock edge on, the block samples the request line on every rising edge while acceptance is open. When it sees a low level, it holds that as one pending request.

A pending request waits for the bus to become free, shown by a high `bus_break`. At that edge the block clears the pending request and begins activation. It raises `cyc_start` for one cycle. It then holds the active-low acknowledge for the whole single transfer cycle, until the bus side reports `cyc_done`. Acceptance stays closed from activation until that cycle ends, so request samples taken in that window are dropped.

Each completed cycle decrements the count. When the last cycle completes, the block returns to the disabled state and raises a sticky transfer-end flag. No data moves through this block. Every pin is a plain control or status level, with no valid/ready handshake and no back-pressure.

Top module: `dma_lvl_req_acceptor`

## Requirements
- R1: While reset is active and after reset is released, `ack_n` is 1, `cyc_start` is 0 and `xfer_end` is 0.
- R2: An enable write (`en_wr`=1, `en_wdata`=1 at a rising edge, block disabled) opens acceptance only when `cfg_level`=1 and `cfg_ext_req`=1. The request line is first sampled at the edge after the write edge, so a low level present only at the write edge is not taken.
- R3: If `cfg_level` or `cfg_ext_req` is 0 at the enable write, no request is accepted and `cyc_start` stays 0.
- R4: A low level on `req_n` sampled while acceptance is open is held as a pending request. It is held for any number of cycles until `bus_break` is sampled high, even if `req_n` has already returned high.
- R5: At the edge where a request is pending and `bus_break` is 1, the pending request is cleared. `cyc_start` is then 1 for exactly the next cycle, with `ack_n` still 1 in that cycle.
- R6: `ack_n` is 0 from the cycle after `cyc_start` up to and including the cycle in which `cyc_done` is sampled high. It returns to 1 in the following cycle.
- R7: Samples of `req_n` taken while a request is pending, during activation or during the transfer cycle are ignored and never queued. A low level seen only in that window produces no further `cyc_start`.
- R8: Acceptance is closed for at least 2 cycles after a request is cleared. With `req_n` held low and `bus_break` and `cyc_done` held high, `cyc_start` pulses exactly once every 4 cycles.
- R9: The transfer count is loaded at the enable write and decremented by each completed cycle. After the count's number of cycles (a load of 0 means 2^CNT_W), the block disables itself, sets `xfer_end` and accepts no further request.
- R10: An enable write with `en_wdata`=0 while acceptance is open closes it and drops any pending request.
- R11: `xfer_end` stays 1 until the next enable write with `en_wdata`=1, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_wr | input | 1 | Write strobe for the channel enable control |
| en_wdata | input | 1 | Enable value written: 1 arms, 0 disables |
| cfg_level | input | 1 | Activation type: 1 selects level-sensitive requests |
| cfg_ext_req | input | 1 | 1 selects the external request line as trigger source |
| xfer_count | input | CNT_W | Number of single cycles, loaded at the enable write |
| req_n | input | 1 | External transfer request, active low |
| bus_break | input | 1 | Bus is free for a DMA cycle |
| cyc_done | input | 1 | Current single transfer cycle completes this cycle |
| ack_n | output | 1 | Transfer acknowledge, active low during the single cycle |
| cyc_start | output | 1 | One-cycle pulse when a single cycle is activated |
| xfer_end | output | 1 | Sticky flag: transfer count exhausted |

## Verification
The bench builds the block with CNT_W=4. With that width, a load of 0 runs all 16 cycles of the wrap-around count and completes in a few hundred clocks. A table walks several counts, bus-wait lengths and transfer-cycle lengths. Directed runs then cover the streaming case that shows the 4-cycle minimum spacing, the write-edge sampling boundary, the mode gating, disabling with a pending request, and the sticky end flag.

// File: rtl/dma_lvl_pkg.sv
package dma_lvl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OPEN = 2'd1,
    ST_ACT  = 2'd2,
    ST_XFER = 2'd3
  } seq_st_t;
endpackage

// File: rtl/dma_req_latch.sv
module dma_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic open_i,
  input  logic req_n_i,
  input  logic drop_i,
  output logic pend_o
);
  // Holds one sampled request; later samples while pending do not stack.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  pend_o <= 1'b0;
    else if (drop_i)             pend_o <= 1'b0;
    else if (open_i && !req_n_i) pend_o <= 1'b1;
  end
endmodule

// File: rtl/dma_xfer_ctr.sv
module dma_xfer_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - ONE;
  end

  // A load of zero wraps through all 2^CNT_W values before reaching one.
  assign last_o = (cnt_q == ONE);
endmodule

// File: rtl/dma_cycle_seq.sv
module dma_cycle_seq
  import dma_lvl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic arm_ok_i,
  input  logic disarm_i,
  input  logic pend_i,
  input  logic bus_break_i,
  input  logic cyc_done_i,
  input  logic last_i,
  output logic open_o,
  output logic drop_o,
  output logic load_o,
  output logic dec_o,
  output logic ack_n_o,
  output logic cyc_start_o,
  output logic xfer_end_o
);
  seq_st_t st_q, st_d;
  logic    act;
  logic    end_q;

  always_comb begin
    st_d  = st_q;
    act   = 1'b0;
    dec_o = 1'b0;
    unique case (st_q)
      ST_IDLE: if (arm_i && arm_ok_i) st_d = ST_OPEN;
      ST_OPEN: begin
        if (disarm_i) st_d = ST_IDLE;
        else if (pend_i && bus_break_i) begin
          act  = 1'b1;
          st_d = ST_ACT;
        end
      end
      ST_ACT:  st_d = ST_XFER;
      ST_XFER: begin
        if (cyc_done_i) begin
          dec_o = 1'b1;
          st_d  = last_i ? ST_IDLE : ST_OPEN;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign load_o = arm_i && (st_q == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              end_q <= 1'b0;
    else if (load_o)         end_q <= 1'b0;
    else if (dec_o && last_i) end_q <= 1'b1;
  end

  assign open_o      = (st_q == ST_OPEN);
  assign drop_o      = act || (open_o && disarm_i);
  assign cyc_start_o = (st_q == ST_ACT);
  assign ack_n_o     = (st_q != ST_XFER);
  assign xfer_end_o  = end_q;
endmodule

// File: rtl/dma_lvl_req_acceptor.sv
module dma_lvl_req_acceptor #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_wr,
  input  logic             en_wdata,
  input  logic             cfg_level,
  input  logic             cfg_ext_req,
  input  logic [CNT_W-1:0] xfer_count,
  input  logic             req_n,
  input  logic             bus_break,
  input  logic             cyc_done,
  output logic             ack_n,
  output logic             cyc_start,
  output logic             xfer_end
);
  logic open_w, drop_w, pend_w, load_w, dec_w, last_w;
  logic arm_w, arm_ok_w, disarm_w;

  assign arm_w    = en_wr && en_wdata;
  assign disarm_w = en_wr && !en_wdata;
  assign arm_ok_w = cfg_level && cfg_ext_req;

  dma_req_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .open_i  (open_w),
    .req_n_i (req_n),
    .drop_i  (drop_w),
    .pend_o  (pend_w)
  );

  dma_xfer_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_w),
    .load_val_i (xfer_count),
    .dec_i      (dec_w),
    .last_o     (last_w)
  );

  dma_cycle_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm_i       (arm_w),
    .arm_ok_i    (arm_ok_w),
    .disarm_i    (disarm_w),
    .pend_i      (pend_w),
    .bus_break_i (bus_break),
    .cyc_done_i  (cyc_done),
    .last_i      (last_w),
    .open_o      (open_w),
    .drop_o      (drop_w),
    .load_o      (load_w),
    .dec_o       (dec_w),
    .ack_n_o     (ack_n),
    .cyc_start_o (cyc_start),
    .xfer_end_o  (xfer_end)
  );
endmodule

// File: rtl/dma_lvl_req_chk.sv
module dma_lvl_req_chk (
  input logic clk,
  input logic rst_n,
  input logic cyc_done,
  input logic ack_n,
  input logic cyc_start,
  input logic xfer_end
);
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> !cyc_start); // R5
  AST_NO_ACK_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |-> ack_n); // R5
  AST_ACK_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> !ack_n); // R6
  AST_ACK_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) |-> $past(cyc_start)); // R6
  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n && !cyc_done) |=> !ack_n); // R6
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n && cyc_done) |=> ack_n); // R6
  AST_MIN_START_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> (!cyc_start ##1 !cyc_start ##1 !cyc_start)); // R8
  AST_END_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |-> (ack_n && !cyc_start)); // R9
endmodule

bind dma_lvl_req_acceptor dma_lvl_req_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cyc_done  (cyc_done),
  .ack_n     (ack_n),
  .cyc_start (cyc_start),
  .xfer_end  (xfer_end)
);

// File: tb/sim_dma_lvl_req_acceptor.sv
module sim_dma_lvl_req_acceptor;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_wr = 1'b0, en_wdata = 1'b0, cfg_level = 1'b0, cfg_ext_req = 1'b0;
  logic [CW-1:0] xfer_count = '0;
  logic req_n = 1'b1, bus_break = 1'b0, cyc_done = 1'b0;
  logic ack_n, cyc_start, xfer_end;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dma_lvl_req_acceptor #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata),
    .cfg_level(cfg_level), .cfg_ext_req(cfg_ext_req), .xfer_count(xfer_count),
    .req_n(req_n), .bus_break(bus_break), .cyc_done(cyc_done),
    .ack_n(ack_n), .cyc_start(cyc_start), .xfer_end(xfer_end)
  );

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic enable(input int cnt, input logic lvl, input logic ext);
    @(negedge clk);
    en_wr = 1'b1; en_wdata = 1'b1; xfer_count = CW'(cnt);
    cfg_level = lvl; cfg_ext_req = ext;
    @(negedge clk);
    en_wr = 1'b0;
  endtask

  // One request pulse, bbw cycles of busy bus, transfer of len cycles.
  task automatic do_xfer(input int bbw, input int len);
    @(negedge clk); req_n = 1'b0; bus_break = 1'b0;
    @(negedge clk); req_n = 1'b1;
    for (int i = 0; i < bbw; i++) begin
      @(negedge clk);
      chk("R4 held while bus busy", cyc_start, 0);
    end
    bus_break = 1'b1;
    @(negedge clk); bus_break = 1'b0;
    chk("R5 start pulse", cyc_start, 1);
    chk("R5 no ack at start", ack_n, 1);
    req_n = 1'b0; // R7: low only while acceptance closed
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      chk("R6 ack low in cycle", ack_n, 0);
      chk("R5 single start", cyc_start, 0);
      if (i == len - 1) cyc_done = 1'b1;
    end
    @(negedge clk); cyc_done = 1'b0; req_n = 1'b1;
    chk("R6 ack released", ack_n, 1);
  endtask

  task automatic no_start(input string r, input int n);
    int seen = 0;
    bus_break = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (cyc_start) seen++;
    end
    bus_break = 1'b0;
    chk(r, seen, 0);
  endtask

  localparam int NV = 3;
  localparam int VEC [NV][3] = '{'{3, 0, 1}, '{2, 3, 4}, '{1, 1, 2}};

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 ack in reset", ack_n, 1);
    chk("R1 start in reset", cyc_start, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 end after reset", xfer_end, 0);

    // Table: count, bus wait, transfer length
    for (int v = 0; v < NV; v++) begin
      enable(VEC[v][0], 1'b1, 1'b1);
      for (int t = 0; t < VEC[v][0]; t++) begin
        do_xfer(VEC[v][1], VEC[v][2]);
        chk("R9 end flag timing", xfer_end, (t == VEC[v][0] - 1) ? 1 : 0);
        if (t < VEC[v][0] - 1) no_start("R7 closed-window request ignored", 2);
      end
      no_start("R9 stopped after end", 3);
      chk("R11 end sticky", xfer_end, 1);
    end

    // R2: low only at the write edge is not sampled
    @(negedge clk);
    en_wr = 1'b1; en_wdata = 1'b1; xfer_count = CW'(2);
    cfg_level = 1'b1; cfg_ext_req = 1'b1; req_n = 1'b0;
    @(negedge clk);
    en_wr = 1'b0; req_n = 1'b1;
    chk("R11 end cleared by enable", xfer_end, 0);
    no_start("R2 write-edge sample ignored", 3);

    // R10: disable drops pending request
    @(negedge clk); req_n = 1'b0;
    @(negedge clk); req_n = 1'b1; en_wr = 1'b1; en_wdata = 1'b0;
    @(negedge clk); en_wr = 1'b0;
    no_start("R10 disable drops pending", 3);

    // R3: mode bits gate acceptance
    enable(2, 1'b0, 1'b1);
    @(negedge clk); req_n = 1'b0;
    no_start("R3 level bit clear", 3);
    req_n = 1'b1;
    enable(2, 1'b1, 1'b0);
    @(negedge clk); req_n = 1'b0;
    no_start("R3 source bit clear", 3);
    req_n = 1'b1;

    // R8: streaming spacing
    enable(3, 1'b1, 1'b1);
    begin
      int starts = 0, last_i = -1, gap_bad = 0, acks = 0;
      @(negedge clk); req_n = 1'b0; bus_break = 1'b1; cyc_done = 1'b1;
      for (int i = 0; i < 16; i++) begin
        @(negedge clk);
        if (!ack_n) acks++;
        if (cyc_start) begin
          if (last_i >= 0 && i - last_i != 4) gap_bad++;
          last_i = i; starts++;
        end
      end
      req_n = 1'b1; bus_break = 1'b0; cyc_done = 1'b0;
      chk("R8 start count", starts, 3);
      chk("R8 start spacing", gap_bad, 0);
      chk("R6 one ack cycle each", acks, 3);
      chk("R9 end after stream", xfer_end, 1);
    end

    // R9: load of zero runs 2^CW cycles
    enable(0, 1'b1, 1'b1);
    for (int t = 0; t < (1 << CW); t++) begin
      do_xfer(0, 1);
      chk("R9 zero-load end timing", xfer_end, (t == (1 << CW) - 1) ? 1 : 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule